// File: doc/BRIEF.md
# Snoop Response Combiner

After an address is broadcast on a shared coherence bus, every cache looks the block up and reports two facts: whether it holds a copy, and whether its copy is modified. This block merges those per-cache reports into one bus-wide view. It drives a shared flag, a dirty flag and a snoop-valid pulse that marks when both flags may be read. It also gives the memory controller one decision per transaction: either supply the data, or stand aside because a cache holds a modified copy and will supply it. The decision does not say which cache holds that copy.

Two timing schemes can be chosen at elaboration. In fixed mode the decision comes a set number of clocks after the address strobe is captured, and the caches must have their answers ready by then. In variable mode each cache raises a per-cache done bit when its lookup finishes. The decision comes as soon as every cache has reported. Until then memory has to assume that some cache may still claim the block, so it may fetch early and hold the data.

Top module: `snoop_combiner`

## Requirements
- R1: When snoop-valid is high, `shared_o` is the OR of the shared reports that were counted for the transaction.
- R2: When snoop-valid is high, `dirty_o` is the OR of the dirty reports that were counted for the transaction.
- R3: While `snoop_vld_o` is low, `shared_o`, `dirty_o`, `mem_respond_o` and `mem_inhibit_o` are all low.
- R4: In fixed mode, `snoop_vld_o` rises on the FIXED_DELAY-th rising edge after the edge that captured the strobe. The counted reports are the `shared_i`/`dirty_i` values present in the clock cycle just before that edge. `done_i` has no effect.
- R5: In variable mode, `snoop_vld_o` rises on the edge that ends the first cycle in which every cache has raised `done_i` at least once since the strobe was captured. A done bit needs to be high for one cycle only.
- R6: In variable mode, a cache's shared/dirty bits are counted only in cycles where its `done_i` bit is high. Any reports or done bits present in the strobe cycle itself are ignored.
- R7: With snoop-valid high, `mem_respond_o` = NOT dirty and `mem_inhibit_o` = dirty, so exactly one of them is high.
- R8: A strobe that arrives while a transaction is pending is ignored. A strobe in the cycle where `snoop_vld_o` is high is accepted.
- R9: After reset all outputs are low and the block is idle.
- R10: `snoop_vld_o` is high for exactly one cycle per accepted transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_vld_i | input | 1 | Address phase strobe on the bus |
| shared_i | input | N_CACHES | Per-cache "holds a copy" report |
| dirty_i | input | N_CACHES | Per-cache "holds a modified copy" report |
| done_i | input | N_CACHES | Per-cache lookup finished (variable mode only) |
| snoop_vld_o | output | 1 | One-cycle pulse: combined flags are valid |
| shared_o | output | 1 | Combined shared flag |
| dirty_o | output | 1 | Combined dirty flag |
| mem_respond_o | output | 1 | Memory shall supply the data |
| mem_inhibit_o | output | 1 | Memory shall stand down |

## Verification
In fixed mode, the merge is tried with no reports, a single sharer, several sharers, a lone dirty owner, a mix and all caches set. This separates a true OR from an AND or a stuck-at bit, and it checks that the respond/inhibit choice follows only the dirty flag. A vector whose bits appear only in the strobe cycle shows that reports are sampled at the deadline and not when the strobe is captured. A repeated strobe during the wait, followed by a strobe in the pulse cycle, tells an ignored strobe from a restarted timer. In variable mode, done bits arrive one cache at a time, and a shared bit is shown with its done low. This tells sticky completion apart from needing all done bits at once, and gated reports apart from ungated ones.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic {
        SNP_FIXED    = 1'b0,
        SNP_VARIABLE = 1'b1
    } snp_mode_e;

endpackage

// File: rtl/snoop_merge.sv
module snoop_merge #(
    parameter int   N_CACHES = 4,
    parameter logic GATE     = 1'b0
) (
    input  logic [N_CACHES-1:0] shared_i,
    input  logic [N_CACHES-1:0] dirty_i,
    input  logic [N_CACHES-1:0] done_i,
    input  logic [N_CACHES-1:0] seen_i,
    output logic                hit_sh_o,
    output logic                hit_dt_o,
    output logic                all_done_o
);

    logic [N_CACHES-1:0] sh_m;
    logic [N_CACHES-1:0] dt_m;

    generate
        if (GATE) begin : g_gated
            assign sh_m = shared_i & done_i;
            assign dt_m = dirty_i & done_i;
        end else begin : g_open
            assign sh_m = shared_i;
            assign dt_m = dirty_i;
        end
    endgenerate

    assign hit_sh_o   = |sh_m;
    assign hit_dt_o   = |dt_m;
    assign all_done_o = &(seen_i | done_i);

endmodule

// File: rtl/snoop_timer.sv
module snoop_timer #(
    parameter int DELAY = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic expire_o
);

    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire_o = tmr_q.busy && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(DELAY - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/snoop_combiner.sv
module snoop_combiner
    import snoop_pkg::*;
#(
    parameter int        N_CACHES    = 4,
    parameter snp_mode_e MODE        = SNP_FIXED,
    parameter int        FIXED_DELAY = 3
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                addr_vld_i,
    input  logic [N_CACHES-1:0] shared_i,
    input  logic [N_CACHES-1:0] dirty_i,
    input  logic [N_CACHES-1:0] done_i,
    output logic                snoop_vld_o,
    output logic                shared_o,
    output logic                dirty_o,
    output logic                mem_respond_o,
    output logic                mem_inhibit_o
);

    localparam logic IS_VAR = (MODE == SNP_VARIABLE);

    typedef struct packed {
        logic                busy;
        logic [N_CACHES-1:0] seen;
        logic                acc_sh;
        logic                acc_dt;
        logic                vld;
        logic                sh;
        logic                dt;
        logic                resp;
        logic                inh;
    } cmb_t;

    cmb_t cmb_d, cmb_q;

    logic hit_sh, hit_dt, all_done;
    logic expire, start, finish;
    logic sh_fin, dt_fin;

    assign start = !cmb_q.busy && addr_vld_i;

    snoop_merge #(
        .N_CACHES (N_CACHES),
        .GATE     (IS_VAR)
    ) u_merge (
        .shared_i   (shared_i),
        .dirty_i    (dirty_i),
        .done_i     (done_i),
        .seen_i     (cmb_q.seen),
        .hit_sh_o   (hit_sh),
        .hit_dt_o   (hit_dt),
        .all_done_o (all_done)
    );

    generate
        if (MODE == SNP_FIXED) begin : g_fixed
            if (FIXED_DELAY < 1) begin : g_bad_delay
                $error("FIXED_DELAY must be at least 1");
            end
            snoop_timer #(
                .DELAY (FIXED_DELAY)
            ) u_timer (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .start_i  (start),
                .expire_o (expire)
            );
            assign finish = cmb_q.busy && expire;
            assign sh_fin = hit_sh;
            assign dt_fin = hit_dt;
        end else begin : g_var
            assign expire = 1'b0;
            assign finish = cmb_q.busy && all_done;
            assign sh_fin = cmb_q.acc_sh | hit_sh;
            assign dt_fin = cmb_q.acc_dt | hit_dt;
        end
    endgenerate

    always_comb begin
        cmb_d      = cmb_q;
        cmb_d.vld  = 1'b0;
        cmb_d.sh   = 1'b0;
        cmb_d.dt   = 1'b0;
        cmb_d.resp = 1'b0;
        cmb_d.inh  = 1'b0;
        if (start) begin
            cmb_d.busy   = 1'b1;
            cmb_d.seen   = '0;
            cmb_d.acc_sh = 1'b0;
            cmb_d.acc_dt = 1'b0;
        end else if (cmb_q.busy) begin
            cmb_d.seen   = cmb_q.seen | done_i;
            cmb_d.acc_sh = cmb_q.acc_sh | hit_sh;
            cmb_d.acc_dt = cmb_q.acc_dt | hit_dt;
            if (finish) begin
                cmb_d.busy = 1'b0;
                cmb_d.vld  = 1'b1;
                cmb_d.sh   = sh_fin;
                cmb_d.dt   = dt_fin;
                cmb_d.resp = !dt_fin;
                cmb_d.inh  = dt_fin;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmb_q <= '0;
        end else begin
            cmb_q <= cmb_d;
        end
    end

    assign snoop_vld_o   = cmb_q.vld;
    assign shared_o      = cmb_q.sh;
    assign dirty_o       = cmb_q.dt;
    assign mem_respond_o = cmb_q.resp;
    assign mem_inhibit_o = cmb_q.inh;

endmodule

// File: rtl/snoop_combiner_chk.sv
module snoop_combiner_chk
    import snoop_pkg::*;
#(
    parameter int        N_CACHES    = 4,
    parameter snp_mode_e MODE        = SNP_FIXED,
    parameter int        FIXED_DELAY = 3
) (
    input logic clk_i,
    input logic rst_ni,
    input logic addr_vld_i,
    input logic snoop_vld_o,
    input logic shared_o,
    input logic dirty_o,
    input logic mem_respond_o,
    input logic mem_inhibit_o
);

    // R3: every flag stays quiet outside the valid pulse
    assert_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !snoop_vld_o |-> !(shared_o || dirty_o || mem_respond_o || mem_inhibit_o));

    // R7: exactly one memory decision, following the dirty flag
    assert_decision_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snoop_vld_o |-> ((mem_respond_o != mem_inhibit_o) && (mem_inhibit_o == dirty_o)));

    // R10: single-cycle pulse
    assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snoop_vld_o |=> !snoop_vld_o);

    generate
        if (MODE == SNP_FIXED) begin : g_fix_chk
            logic busy_q;
            int   left_q;
            logic exp_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    busy_q <= 1'b0;
                    left_q <= 0;
                    exp_q  <= 1'b0;
                end else begin
                    exp_q <= 1'b0;
                    if (!busy_q) begin
                        if (addr_vld_i) begin
                            busy_q <= 1'b1;
                            left_q <= FIXED_DELAY - 1;
                        end
                    end else if (left_q == 0) begin
                        busy_q <= 1'b0;
                        exp_q  <= 1'b1;
                    end else begin
                        left_q <= left_q - 1;
                    end
                end
            end

            // R4, R8: pulse lands exactly FIXED_DELAY edges after an accepted strobe
            assert_fixed_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                snoop_vld_o == exp_q);
        end
    endgenerate

endmodule

bind snoop_combiner snoop_combiner_chk #(
    .N_CACHES    (N_CACHES),
    .MODE        (MODE),
    .FIXED_DELAY (FIXED_DELAY)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_vld_i    (addr_vld_i),
    .snoop_vld_o   (snoop_vld_o),
    .shared_o      (shared_o),
    .dirty_o       (dirty_o),
    .mem_respond_o (mem_respond_o),
    .mem_inhibit_o (mem_inhibit_o)
);

// File: tb/sim_snoop_combiner.sv
`timescale 1ns/1ps
module sim_snoop_combiner;
    import snoop_pkg::*;

    localparam int NC = 4;
    localparam int FD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // fixed-mode DUT signals
    logic          fa = 1'b0;
    logic [NC-1:0] fs = '0, ft = '0, fd = '0;
    logic f_vld, f_sh, f_dt, f_rsp, f_inh;
    // variable-mode DUT signals
    logic          va = 1'b0;
    logic [NC-1:0] vs = '0, vt = '0, vd = '0;
    logic v_vld, v_sh, v_dt, v_rsp, v_inh;

    int tests = 0;
    int fails = 0;

    snoop_combiner #(.N_CACHES(NC), .MODE(SNP_FIXED), .FIXED_DELAY(FD)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .addr_vld_i(fa),
        .shared_i(fs), .dirty_i(ft), .done_i(fd),
        .snoop_vld_o(f_vld), .shared_o(f_sh), .dirty_o(f_dt),
        .mem_respond_o(f_rsp), .mem_inhibit_o(f_inh));

    snoop_combiner #(.N_CACHES(NC), .MODE(SNP_VARIABLE), .FIXED_DELAY(FD)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .addr_vld_i(va),
        .shared_i(vs), .dirty_i(vt), .done_i(vd),
        .snoop_vld_o(v_vld), .shared_o(v_sh), .dirty_o(v_dt),
        .mem_respond_o(v_rsp), .mem_inhibit_o(v_inh));

    // {shared[3:0], dirty[3:0], exp_shared, exp_dirty}
    localparam logic [9:0] FVEC [6] = '{
        10'b0000_0000_0_0,
        10'b0001_0000_1_0,
        10'b1010_0000_1_0,
        10'b0000_1000_0_1,
        10'b0110_0100_1_1,
        10'b1111_1111_1_1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_f_all(input string tag, input logic vld, input logic sh, input logic dt);
        chk({tag, " vld"}, 32'(f_vld), 32'(vld));
        chk({tag, " shared R1"}, 32'(f_sh), 32'(sh));
        chk({tag, " dirty R2"}, 32'(f_dt), 32'(dt));
        chk({tag, " respond R7"}, 32'(f_rsp), 32'(vld & ~dt));
        chk({tag, " inhibit R7"}, 32'(f_inh), 32'(vld & dt));
    endtask

    task automatic fixed_run(input logic [NC-1:0] sh, input logic [NC-1:0] dt,
                             input logic hold, input logic esh, input logic edt);
        @(negedge clk);
        fa = 1'b1; fs = sh; ft = dt; fd = '1;
        @(negedge clk);
        fa = 1'b0;
        if (!hold) begin fs = '0; ft = '0; end
        chk("R4 wait", 32'(f_vld), 32'd0);
        for (int k = 1; k < FD; k++) begin
            @(negedge clk);
            chk("R4 wait R3 quiet", 32'({f_vld, f_sh, f_dt, f_rsp, f_inh}), 32'd0);
        end
        @(negedge clk);
        check_f_all("R4 decision", 1'b1, esh, edt);
        fs = '0; ft = '0; fd = '0;
        @(negedge clk);
        chk("R10 one cycle", 32'(f_vld), 32'd0);
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        // R9 reset state
        #1;
        chk("R9 reset fixed", 32'({f_vld, f_sh, f_dt, f_rsp, f_inh}), 32'd0);
        chk("R9 reset var", 32'({v_vld, v_sh, v_dt, v_rsp, v_inh}), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 idle after reset", 32'({f_vld, v_vld}), 32'd0);

        // fixed-mode vector table (R1, R2, R4, R7)
        for (int i = 0; i < 6; i++) begin
            fixed_run(FVEC[i][9:6], FVEC[i][5:2], 1'b1, FVEC[i][1], FVEC[i][0]);
        end

        // R4: reports present only in the strobe cycle are not counted
        fixed_run(4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0);

        // R8: second strobe during wait ignored; strobe in pulse cycle accepted
        @(negedge clk);
        fa = 1'b1; fs = 4'b0010; ft = 4'b0000;
        @(negedge clk);                       // capture edge passed; strobe held one more cycle
        chk("R8 wait0", 32'(f_vld), 32'd0);
        @(negedge clk);
        fa = 1'b0;
        chk("R8 wait1", 32'(f_vld), 32'd0);
        @(negedge clk);
        chk("R8 wait2", 32'(f_vld), 32'd0);
        @(negedge clk);
        check_f_all("R8 first pulse", 1'b1, 1'b1, 1'b0);
        fa = 1'b1; ft = 4'b0100;               // strobe in the pulse cycle
        @(negedge clk);
        fa = 1'b0;
        chk("R8 no restart pulse a", 32'(f_vld), 32'd0);
        @(negedge clk);
        chk("R8 no restart pulse b", 32'(f_vld), 32'd0);
        @(negedge clk);
        chk("R8 no restart pulse c", 32'(f_vld), 32'd0);
        @(negedge clk);
        check_f_all("R8 back-to-back pulse", 1'b1, 1'b1, 1'b1);
        fs = '0; ft = '0;
        @(negedge clk);
        chk("R10 after back-to-back", 32'(f_vld), 32'd0);

        // variable mode: done bits trickle in, strobe-cycle reports ignored (R5, R6)
        @(negedge clk);
        va = 1'b1; vd = 4'b1111; vs = 4'b1111; vt = 4'b1111;
        @(negedge clk);
        va = 1'b0; vd = 4'b0001; vs = 4'b0001; vt = 4'b0000;
        chk("R6 strobe-cycle done ignored", 32'(v_vld), 32'd0);
        @(negedge clk);
        vd = 4'b0010; vs = 4'b0000; vt = 4'b0010;
        chk("R5 wait a", 32'(v_vld), 32'd0);
        @(negedge clk);
        vd = 4'b0000; vs = 4'b0100; vt = 4'b1000;
        chk("R5 wait b", 32'(v_vld), 32'd0);
        @(negedge clk);
        vd = 4'b1100; vs = 4'b0000; vt = 4'b0000;
        chk("R5 wait c sticky", 32'(v_vld), 32'd0);
        @(negedge clk);
        vd = 4'b0000;
        chk("R5 pulse after last done", 32'(v_vld), 32'd1);
        chk("R1 var shared", 32'(v_sh), 32'd1);
        chk("R2 var dirty", 32'(v_dt), 32'd1);
        chk("R7 var inhibit", 32'({v_rsp, v_inh}), 32'b01);
        @(negedge clk);
        chk("R10 var one cycle", 32'(v_vld), 32'd0);

        // R6: shared with done low is not counted
        @(negedge clk);
        va = 1'b1; vd = 4'b0000; vs = 4'b0000; vt = 4'b0000;
        @(negedge clk);
        va = 1'b0; vd = 4'b1011; vs = 4'b0100; vt = 4'b0100;
        @(negedge clk);
        vd = 4'b0100; vs = 4'b0000; vt = 4'b0000;
        chk("R5 partial done waits", 32'(v_vld), 32'd0);
        @(negedge clk);
        vd = 4'b0000;
        chk("R5 var pulse", 32'(v_vld), 32'd1);
        chk("R6 ungated shared ignored", 32'(v_sh), 32'd0);
        chk("R6 ungated dirty ignored", 32'(v_dt), 32'd0);
        chk("R7 var respond", 32'({v_rsp, v_inh}), 32'b10);
        @(negedge clk);
        chk("R3 var quiet", 32'({v_vld, v_sh, v_dt, v_rsp, v_inh}), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule